// File: doc/BRIEF.md
# One-Time-Programmable Array Write Sequencer

This block is the byte-level controller behind a serial slave's write commands for a one-time-programmable store. A bit-timing layer hands it bytes received from the bus master and takes bytes from it to shift back out. The controller decodes a write command, collects a two-byte start address and a data byte, and answers with an 8-bit CRC of what it heard. It then waits for an external programming-pulse indication and applies the byte to the array. Bits can only be cleared, never set. Finally it returns the byte now stored at the target.

After each readback the address pointer advances. The master may then send another data byte. This time the CRC is seeded with the new low address byte and covers only the new data. The same sequencer serves a 128-byte main field, split into four 32-byte pages, and an 8-byte status field. In the status field, status byte 0 holds one lock flag per main page. A bus reset abandons the sequence at any point.

Top module: `otp_write_seq`

## Requirements
- R1: Command byte 0Fh selects the 128-byte main field and command byte 55h selects the 8-byte status field. Any other command byte is ignored: until the next bus reset the block sends nothing and writes nothing.
- R2: After the command come the address low byte, then the address high byte, then one data byte. The 16-bit pointer is {high, low}, and only pointer values below the field size address the array.
- R3: After the first data byte the block offers one transmit byte. It is the CRC with polynomial x^8+x^5+x^4+1, reflected form, processed least significant bit first and starting from 00h, taken over the command, address low, address high and data bytes in that order.
- R4: A programming-pulse indication received while the block waits after a CRC leads to exactly one array write. The stored byte becomes old AND data, and that stored byte is then offered as the transmit byte.
- R5: Once the readback byte is accepted, the pointer increments by one. The block then waits for the next data byte. The CRC for that byte is seeded with the new pointer low byte and covers only the data byte.
- R6: A main-field byte at pointer p belongs to page p[6:5]. When bit p[6:5] of status byte 0 is 0, a write to that page leaves the array unchanged and the readback returns the unchanged byte. Status-field writes are never locked.
- R7: When the pointer is at or past the end of the selected field, a programming pulse writes nothing and the readback byte is FFh.
- R8: A bus reset in any state discards the sequence. The block returns to waiting for a command, with nothing offered for transmit and no write in the following cycle.
- R9: A programming-pulse indication that arrives in any state other than the wait after a CRC has no effect. Received bytes that arrive while a byte is being offered or a pulse is awaited are ignored.
- R10: An offered transmit byte stays offered and unchanged until the transmit side accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Bus reset seen on the serial line; aborts the sequence |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | A byte is offered for transmission |
| tx_byte | output | 8 | Offered byte (CRC or readback) |
| tx_ready | input | 1 | Transmit side accepts the offered byte this cycle |
| pulse_det | input | 1 | One-cycle strobe: programming pulse detected |
| mem_field | output | 1 | Array field select: 0 main field, 1 status field |
| mem_addr | output | 7 | Array byte address within the selected field |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Byte to store |
| mem_rdata | input | 8 | Byte at mem_field/mem_addr, combinational read |

## Verification
The assertions assume several things about the inputs. Received-byte and pulse strobes last one cycle. The array answers a read in the same cycle, so the byte the block stores may be related to the byte it read. A pulse arrives only after the CRC has been taken, which ties every write to a pulse one or two cycles earlier. The bench drives every strobe for exactly one cycle from the falling edge and models the array as a combinational read with a write on the clock edge. It issues pulses only where the protocol allows them, except in tests where a stray pulse is the stimulus under test.

// File: rtl/otpw_pkg.sv
package otpw_pkg;

    typedef enum logic [3:0] {
        S_CMD,
        S_ALO,
        S_AHI,
        S_DAT,
        S_CRC,
        S_WAIT,
        S_LOCK,
        S_PROG,
        S_RDBK,
        S_SKIP
    } seq_state_e;

    typedef enum logic {
        FLD_MAIN = 1'b0,
        FLD_STAT = 1'b1
    } field_e;

    // Reflected form of x^8+x^5+x^4+1
    localparam logic [7:0] CRC_POLY_REFL = 8'h8C;

    function automatic logic [7:0] crc8_step(input logic [7:0] acc, input logic [7:0] b);
        logic [7:0] r;
        logic       fb;
        r = acc;
        for (int i = 0; i < 8; i++) begin
            fb = r[0] ^ b[i];
            r  = r >> 1;
            if (fb) r = r ^ CRC_POLY_REFL;
        end
        return r;
    endfunction

endpackage

// File: rtl/otpw_crc_acc.sv
module otpw_crc_acc
    import otpw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       seed_ld,
    input  logic [7:0] seed,
    input  logic       upd,
    input  logic [7:0] din,
    output logic [7:0] crc
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc <= 8'h00;
        end else if (seed_ld) begin
            crc <= seed;
        end else if (upd) begin
            crc <= crc8_step(crc, din);
        end
    end

    // R5
    crc_seed_chk: assert property (@(posedge clk) disable iff (rst)
        (seed_ld && !clr) |=> (crc == $past(seed)));

endmodule

// File: rtl/otpw_ptr.sv
module otpw_ptr #(
    parameter int DATA_BYTES = 128,
    parameter int STAT_BYTES = 8,
    parameter int PAGE_BYTES = 32,
    localparam int PTR_W = 16,
    localparam int AW    = $clog2(DATA_BYTES),
    localparam int PAGES = DATA_BYTES / PAGE_BYTES,
    localparam int PBW   = $clog2(PAGE_BYTES),
    localparam int PGW   = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic             inc,
    input  logic [7:0]       din,
    input  logic             field,
    output logic [PTR_W-1:0] ptr,
    output logic [7:0]       nxt_lo,
    output logic             in_range,
    output logic [AW-1:0]    arr_addr,
    output logic [PGW-1:0]   page
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ptr <= '0;
        end else if (ld_lo) begin
            ptr[7:0] <= din;
        end else if (ld_hi) begin
            ptr[15:8] <= din;
        end else if (inc) begin
            ptr <= ptr + 16'd1;
        end
    end

    assign nxt_lo   = ptr[7:0] + 8'd1;
    assign arr_addr = ptr[AW-1:0];
    assign in_range = field ? (32'(ptr) < STAT_BYTES) : (32'(ptr) < DATA_BYTES);

    generate
        if (PAGES > 1) begin : g_paged
            assign page = ptr[AW-1:PBW];
        end else begin : g_flat
            assign page = '0;
        end
    endgenerate

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && !ld_lo && !ld_hi) |=> (ptr == $past(ptr) + 16'd1));

endmodule

// File: rtl/otp_write_seq.sv
module otp_write_seq
    import otpw_pkg::*;
#(
    parameter int         DATA_BYTES  = 128,
    parameter int         STAT_BYTES  = 8,
    parameter int         PAGE_BYTES  = 32,
    parameter logic [7:0] CMD_WR_MAIN = 8'h0F,
    parameter logic [7:0] CMD_WR_STAT = 8'h55,
    parameter int         LOCK_BYTE   = 0,
    localparam int        AW          = $clog2(DATA_BYTES),
    localparam int        PAGES       = DATA_BYTES / PAGE_BYTES,
    localparam int        PGW         = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_reset,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    output logic          tx_valid,
    output logic [7:0]    tx_byte,
    input  logic          tx_ready,
    input  logic          pulse_det,
    output logic          mem_field,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata
);

    seq_state_e st;
    field_e     field;
    logic [7:0] dat;
    logic [7:0] rb;
    logic       locked;

    logic [15:0]    ptr;
    logic [7:0]     ptr_nxt_lo;
    logic           in_range;
    logic [AW-1:0]  arr_addr;
    logic [PGW-1:0] page;
    logic [7:0]     crc;

    logic cmd_ok;
    logic ptr_ld_lo, ptr_ld_hi, ptr_inc;
    logic crc_seed_ld, crc_upd;
    logic [7:0] crc_seed;

    assign cmd_ok    = (rx_byte == CMD_WR_MAIN) || (rx_byte == CMD_WR_STAT);
    assign ptr_ld_lo = (st == S_ALO) && rx_valid;
    assign ptr_ld_hi = (st == S_AHI) && rx_valid;
    assign ptr_inc   = (st == S_RDBK) && tx_ready;

    assign crc_seed_ld = ((st == S_CMD) && rx_valid && cmd_ok) || ptr_inc;
    assign crc_seed    = (st == S_CMD) ? crc8_step(8'h00, rx_byte) : ptr_nxt_lo;
    assign crc_upd     = rx_valid && ((st == S_ALO) || (st == S_AHI) || (st == S_DAT));

    otpw_ptr #(
        .DATA_BYTES(DATA_BYTES),
        .STAT_BYTES(STAT_BYTES),
        .PAGE_BYTES(PAGE_BYTES)
    ) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .clr     (bus_reset),
        .ld_lo   (ptr_ld_lo),
        .ld_hi   (ptr_ld_hi),
        .inc     (ptr_inc),
        .din     (rx_byte),
        .field   (field == FLD_STAT),
        .ptr     (ptr),
        .nxt_lo  (ptr_nxt_lo),
        .in_range(in_range),
        .arr_addr(arr_addr),
        .page    (page)
    );

    otpw_crc_acc u_crc (
        .clk    (clk),
        .rst    (rst),
        .clr    (bus_reset),
        .seed_ld(crc_seed_ld),
        .seed   (crc_seed),
        .upd    (crc_upd),
        .din    (rx_byte),
        .crc    (crc)
    );

    always_ff @(posedge clk) begin
        if (rst || bus_reset) begin
            st     <= S_CMD;
            field  <= FLD_MAIN;
            dat    <= 8'h00;
            rb     <= 8'h00;
            locked <= 1'b0;
        end else begin
            unique case (st)
                S_CMD: if (rx_valid) begin
                    if (cmd_ok) begin
                        field <= (rx_byte == CMD_WR_STAT) ? FLD_STAT : FLD_MAIN;
                        st    <= S_ALO;
                    end else begin
                        st <= S_SKIP;
                    end
                end
                S_ALO: if (rx_valid) st <= S_AHI;
                S_AHI: if (rx_valid) st <= S_DAT;
                S_DAT: if (rx_valid) begin
                    dat <= rx_byte;
                    st  <= S_CRC;
                end
                S_CRC: if (tx_ready) st <= S_WAIT;
                S_WAIT: if (pulse_det) begin
                    locked <= 1'b0;
                    if (!in_range) begin
                        rb <= 8'hFF;
                        st <= S_RDBK;
                    end else if (field == FLD_MAIN) begin
                        st <= S_LOCK;
                    end else begin
                        st <= S_PROG;
                    end
                end
                S_LOCK: begin
                    locked <= !mem_rdata[page];
                    st     <= S_PROG;
                end
                S_PROG: begin
                    rb <= locked ? mem_rdata : (mem_rdata & dat);
                    st <= S_RDBK;
                end
                S_RDBK: if (tx_ready) st <= S_DAT;
                S_SKIP: st <= S_SKIP;
                default: st <= S_CMD;
            endcase
        end
    end

    assign tx_valid  = (st == S_CRC) || (st == S_RDBK);
    assign tx_byte   = (st == S_CRC) ? crc : rb;
    assign mem_field = (st == S_LOCK) ? FLD_STAT : field;
    assign mem_addr  = (st == S_LOCK) ? AW'(LOCK_BYTE) : arr_addr;
    assign mem_we    = (st == S_PROG) && !locked && !bus_reset;
    assign mem_wdata = mem_rdata & dat;

    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !bus_reset) |=> (tx_valid && $stable(tx_byte)));

    // R8
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (!tx_valid && !mem_we));

    // R9
    pulse_link_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($past(pulse_det) || $past(pulse_det, 2)));

    // R4
    single_we_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R7
    range_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ((mem_field == FLD_STAT) ? (32'(ptr) < STAT_BYTES)
                                            : (32'(ptr) < DATA_BYTES)));

endmodule

// File: tb/otp_write_seq_test.sv
module otp_write_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_reset = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       tx_ready = 1'b0;
    logic       pulse_det = 1'b0;
    logic       mem_field;
    logic [6:0] mem_addr;
    logic       mem_we;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;

    int checks = 0;
    int failures = 0;
    int we_count = 0;
    int tx_seen = 0;

    logic [7:0] mem_d [128];
    logic [7:0] mem_s [8];
    logic [7:0] m_d [128];
    logic [7:0] m_s [8];

    always #2 clk = ~clk;

    otp_write_seq uut (
        .clk(clk), .rst(rst), .bus_reset(bus_reset),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
        .pulse_det(pulse_det),
        .mem_field(mem_field), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem_field ? mem_s[mem_addr[2:0]] : mem_d[mem_addr];

    always @(posedge clk) begin
        if (mem_we) begin
            we_count++;
            if (mem_field) mem_s[mem_addr[2:0]] <= mem_wdata;
            else           mem_d[mem_addr] <= mem_wdata;
        end
        if (tx_valid) tx_seen++;
    end

    // Shift-register form of x^8+x^5+x^4+1, LSB first
    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r;
        logic [7:0] n;
        logic       s;
        r = c;
        for (int i = 0; i < 8; i++) begin
            s = r[0] ^ b[i];
            n = {s, r[7:1]};
            n[3] = r[4] ^ s;
            n[2] = r[3] ^ s;
            r = n;
        end
        return r;
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic take(output logic [7:0] b, input string tag);
        int n;
        n = 0;
        @(negedge clk);
        while (!tx_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(tx_valid, tag, 0, 1);
        b = tx_byte;
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        pulse_det = 1'b1;
        @(negedge clk);
        pulse_det = 1'b0;
    endtask

    task automatic breset();
        @(negedge clk);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
    endtask

    task automatic wr_seq(input logic [7:0] cmd, input logic [15:0] a, input int n,
                          input logic [7:0] d0, input string rtag);
        logic [7:0]  d, got, exp, ecrc;
        logic [15:0] ad;
        logic        stf, lk;
        send(cmd);
        send(a[7:0]);
        send(a[15:8]);
        for (int i = 0; i < n; i++) begin
            d  = d0 ^ 8'(i * 37);
            ad = a + 16'(i);
            send(d);
            if (i == 0) ecrc = ref_crc(ref_crc(ref_crc(ref_crc(8'h00, cmd), a[7:0]), a[15:8]), d);
            else        ecrc = ref_crc(ad[7:0], d);
            take(got, (i == 0) ? "R3 crc" : "R5 crc");
            check(got == ecrc, (i == 0) ? "R3 first crc" : "R5 seeded crc", got, ecrc);
            pulse();
            stf = (cmd == 8'h55);
            if (stf ? (ad >= 16'd8) : (ad >= 16'd128)) begin
                exp = 8'hFF;
            end else if (stf) begin
                exp = m_s[ad[2:0]] & d;
                m_s[ad[2:0]] = exp;
            end else begin
                lk = !m_s[0][ad[6:5]];
                exp = lk ? m_d[ad[6:0]] : (m_d[ad[6:0]] & d);
                m_d[ad[6:0]] = exp;
            end
            take(got, rtag);
            check(got == exp, rtag, got, exp);
        end
        breset();
    endtask

    task automatic cmp_mem(input string tag);
        int bad;
        bad = 0;
        for (int i = 0; i < 128; i++) if (mem_d[i] !== m_d[i]) bad++;
        for (int i = 0; i < 8; i++) if (mem_s[i] !== m_s[i]) bad++;
        check(bad == 0, tag, bad, 0);
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int wc0, tx0;
        logic [7:0] got, held;
        for (int i = 0; i < 128; i++) begin mem_d[i] = 8'hFF; m_d[i] = 8'hFF; end
        for (int i = 0; i < 8; i++) begin mem_s[i] = 8'hFF; m_s[i] = 8'hFF; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state: nothing offered, nothing written
        check(!tx_valid, "R8 reset tx_valid", tx_valid, 0);
        check(we_count == 0, "R8 reset writes", we_count, 0);

        // R4 R5 sweep over every main page, then overwrite to exercise AND
        for (int p = 0; p < 4; p++)
            wr_seq(8'h0F, 16'(p * 32 + p * 7), 4, 8'(8'hA5 ^ (p * 8'h3C)), "R4 readback");
        for (int p = 0; p < 4; p++)
            wr_seq(8'h0F, 16'(p * 32 + p * 7 + 1), 3, 8'(8'h5A + p), "R4 and-merge");
        cmp_mem("R4 array contents");

        // R7 end of each field; R2 high byte steers out of range
        wr_seq(8'h55, 16'h0006, 3, 8'hC3, "R7 status end");
        wr_seq(8'h0F, 16'h007E, 3, 8'h96, "R7 main end");
        wc0 = we_count;
        wr_seq(8'h0F, 16'h0105, 2, 8'h00, "R2 high byte range");
        check(we_count == wc0, "R2 no write high", we_count, wc0);
        cmp_mem("R7 array contents");

        // R6 lock page 1 via status byte 0 bit 1
        wr_seq(8'h55, 16'h0000, 1, 8'hFD, "R6 set lock");
        wc0 = we_count;
        wr_seq(8'h0F, 16'h0025, 2, 8'h00, "R6 locked readback");
        check(we_count == wc0, "R6 locked no write", we_count, wc0);
        wr_seq(8'h0F, 16'h0048, 2, 8'h0F, "R6 unlocked page");
        cmp_mem("R6 array contents");

        // R1 unknown command ignored until bus reset
        wc0 = we_count;
        tx0 = tx_seen;
        send(8'hAA); send(8'h10); send(8'h00); send(8'h00);
        pulse();
        repeat (20) @(negedge clk);
        check(tx_seen == tx0, "R1 no tx after bad cmd", tx_seen, tx0);
        check(we_count == wc0, "R1 no write after bad cmd", we_count, wc0);
        breset();
        wr_seq(8'h0F, 16'h0011, 1, 8'h3E, "R1 recovers");

        // R8 abort after CRC, before pulse
        wc0 = we_count;
        send(8'h0F); send(8'h30); send(8'h00); send(8'h00);
        take(got, "R8 crc");
        breset();
        pulse();
        repeat (10) @(negedge clk);
        check(we_count == wc0, "R8 abort no write", we_count, wc0);
        check(!tx_valid, "R8 abort no tx", tx_valid, 0);

        // R9 early pulse and bytes during wait ignored
        send(8'h0F); send(8'h50);
        pulse();
        send(8'h00);
        pulse();
        check(we_count == wc0, "R9 early pulse", we_count, wc0);
        send(8'h00);
        take(got, "R9 crc");
        send(8'h77);
        repeat (5) @(negedge clk);
        check(!tx_valid && we_count == wc0, "R9 rx in wait", we_count, wc0);
        breset();
        cmp_mem("R9 array contents");

        // R10 offered byte held while not accepted
        send(8'h0F); send(8'h60); send(8'h00); send(8'h12);
        @(negedge clk);
        held = tx_byte;
        repeat (6) @(negedge clk);
        check(tx_valid && tx_byte == held, "R10 hold", tx_byte, held);
        check(held == ref_crc(ref_crc(ref_crc(ref_crc(8'h00, 8'h0F), 8'h60), 8'h00), 8'h12),
              "R10 held crc", held, 0);
        breset();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule